// File: doc/BRIEF.md
# Gated Clock and Buzzer Output Port

A four-bit output port whose register bits normally drive four output pins directly. Two of the pins can be given a special role through elaboration parameters. Pin 2 can carry the reference clock divided by a power of two from 1 to 128. Instead, it can carry the complement of the buzzer tone, which makes a push-pull buzzer pair with pin 3. Pin 3 can carry a buzzer tone at the reference clock divided by 8 or by 16. In a special role the register bit is an enable: 1 lets the signal through and 0 holds the pin low.

Software writes the register with a one-cycle write strobe and reads it back through a combinational read port. Enabling and disabling a special signal is phase-aligned. A new enable value is accepted only at an edge after which the source signal is low. The pin therefore never shows a high pulse shorter than the source's own high phase, and a disabled pin always rests low. This holds for the inverted buzzer pin too. The elaboration rejects any parameter set that is not allowed: a clock divisor outside the range, a buzzer divisor other than 8 or 16, an inverted buzzer on pin 2 without a buzzer on pin 3, or a port narrower than four bits. Clock output and inverted buzzer are two values of one mode parameter, so they cannot both be selected.

Top module: `tgp_port`

## Requirements
- R1: A pin in plain mode outputs its register bit. Pins 0 and 1 are always plain, and pins 2 and 3 are plain when their mode parameter selects plain.
- R2: After synchronous active-low reset, the register holds 0, every pin is low and a read returns 0.
- R3: While rd_en is 1, rd_data equals the register contents. While rd_en is 0, rd_data is 0.
- R4: A clock edge with wr_en at 1 loads wr_data into the register, and the new value appears on the plain pins after that edge. A clock edge with wr_en at 0 leaves the register unchanged, whatever wr_data holds.
- R5: In clock-out mode with divisor exponent K from 1 to 7, pin 2 equals bit K-1 of the count of rising clock edges since reset, ANDed with its gate. With K = 0, pin 2 follows the high phase of clk whenever bit 2 was 1 at the preceding falling edge.
- R6: In buzzer mode, pin 3 equals bit B-1 of the edge count, ANDed with its gate. B is 3 for a divide-by-8 tone and 4 for a divide-by-16 tone.
- R7: In inverted-buzzer mode, pin 2 equals the complement of bit B-1 of the edge count, ANDed with a gate taken from register bit 2.
- R8: Each gate takes the value of its register bit only at a rising edge after which its source (true or inverted) is 0. At other edges the gate keeps its value. A pin therefore rises and falls only together with its source, and it is never high while its source is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; source of all divided signals |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | PORT_W | Value loaded into the register on a write |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | PORT_W | Register contents while reading, else zero |
| pin_out | output | PORT_W | Output pins |

## Verification
The assertions check on every cycle that a gated pin is high only while its source is at the active level. They also check that it rises and falls only on the source's own edges, that writes reach the plain pins on the next cycle, and that reads return zero or the plain pin levels. The check that each enable change lands at exactly the right phase, and the check that writes are ignored while the strobe is low, are made only by the bench. Its sweep writes every register value at phases that shift against both dividers and compares the result with a cycle-counting model. The same holds for the divide-by-one clock path, which changes on the falling edge and is sampled by the bench in the high phase.

// File: rtl/tgp_pkg.sv
// Package: shared mode encodings and limits for the gated output port.
// Assumes: pin indices of the special roles are fixed at 2 and 3.
package tgp_pkg;

    typedef enum logic [1:0] {
        P2_PLAIN  = 2'd0,
        P2_CLKOUT = 2'd1,
        P2_INVBUZ = 2'd2
    } pin2_mode_e;

    typedef enum logic {
        P3_PLAIN = 1'b0,
        P3_BUZZ  = 1'b1
    } pin3_mode_e;

    localparam int PIN_CLK      = 2;
    localparam int PIN_BUZ      = 3;
    localparam int MAX_CLK_LOG2 = 7;
    localparam int BUZ_LOG2_LO  = 3;
    localparam int BUZ_LOG2_HI  = 4;
    localparam int MIN_PORT_W   = 4;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tgp_divider.sv
// Module: free-running edge counter that supplies two divided bits and
// the values those bits take after the next rising edge.
// Assumes: A_IDX and B_IDX are below CNT_W; counting restarts at reset.
module tgp_divider #(
    parameter int CNT_W = 4,
    parameter int A_IDX = 0,
    parameter int B_IDX = 0
) (
    input  logic clk,
    input  logic rst_n,
    output logic a_bit,
    output logic a_nxt,
    output logic b_bit,
    output logic b_nxt
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Value of bit idx after one increment: flips when all lower bits are 1.
    function automatic logic step_bit(input logic [CNT_W-1:0] c, input int idx);
        logic carry;
        carry = 1'b1;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < idx) carry = carry & c[i];
        end
        return c[idx] ^ carry;
    endfunction

    // Next counter value.
    assign cnt_d = cnt_q + CNT_W'(1);

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Selected bits and their look-ahead.
    assign a_bit = cnt_q[A_IDX];
    assign b_bit = cnt_q[B_IDX];
    assign a_nxt = step_bit(cnt_q, A_IDX);
    assign b_nxt = step_bit(cnt_q, B_IDX);

endmodule

// File: rtl/tgp_phase_gate.sv
// Module: phase-aligned enable gate for a register-clocked divided source.
// The enable is accepted only at an edge after which the source is low,
// so the pin never produces a partial high phase.
// Assumes: src_nxt is the raw source value after the coming rising edge.
module tgp_phase_gate #(
    parameter bit INVERT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_bit,
    input  logic src_nxt,
    input  logic en_req,
    output logic pin
);

    logic s_now;
    logic s_next;
    logic gate_q;

    // Apply the polarity of this pin's source.
    assign s_now  = src_bit ^ INVERT;
    assign s_next = src_nxt ^ INVERT;

    // Gate register: follows the enable only into a low source phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       gate_q <= 1'b0;
        else if (!s_next) gate_q <= en_req;
    end

    // Gated pin, low whenever the gate is closed.
    assign pin = s_now & gate_q;

endmodule

// File: rtl/tgp_fast_gate.sv
// Module: enable gate for the undivided reference clock. The gate is
// sampled on the falling edge so it changes only while clk is low.
// Assumes: the enable is stable around the falling edge of clk.
module tgp_fast_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    output logic pin
);

    logic gate_q;

    // Gate register on the low phase of the clock.
    always_ff @(negedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= en_req;
    end

    // Clock passes only through an open gate.
    assign pin = clk & gate_q;

endmodule

// File: rtl/tgp_data_reg.sv
// Module: port data register with write strobe and zero-idle read port.
// Assumes: wr_en and wr_data are synchronous to clk.
module tgp_data_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] reg_q
);

    // Register update on the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     reg_q <= '0;
        else if (wr_en) reg_q <= wr_data;
    end

    // Read mux: contents while reading, zero otherwise.
    assign rd_data = rd_en ? reg_q : '0;

endmodule

// File: rtl/tgp_port.sv
// Module: output port with optional divided-clock, buzzer and inverted
// buzzer roles on pins 2 and 3. Register bits act as gates in those roles.
// Assumes: synchronous active-low reset; parameters checked at elaboration.
module tgp_port
    import tgp_pkg::*;
#(
    parameter int         PORT_W       = 4,
    parameter pin2_mode_e PIN2_MODE    = P2_CLKOUT,
    parameter pin3_mode_e PIN3_MODE    = P3_BUZZ,
    parameter int         CLK_DIV_LOG2 = 3,
    parameter int         BUZ_DIV_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [PORT_W-1:0] rd_data,
    output logic [PORT_W-1:0] pin_out
);

    localparam int CNT_W   = max3(CLK_DIV_LOG2, BUZ_DIV_LOG2, 1);
    localparam int CLK_IDX = (CLK_DIV_LOG2 > 0) ? CLK_DIV_LOG2 - 1 : 0;
    localparam int BUZ_IDX = (BUZ_DIV_LOG2 > 0) ? BUZ_DIV_LOG2 - 1 : 0;

    // Elaboration-time legality checks.
    if (PORT_W < MIN_PORT_W) begin : g_bad_width
        $error("tgp_port: PORT_W must be at least 4");
    end
    if (CLK_DIV_LOG2 < 0 || CLK_DIV_LOG2 > MAX_CLK_LOG2) begin : g_bad_clkdiv
        $error("tgp_port: clock divisor exponent must be 0 to 7");
    end
    if (BUZ_DIV_LOG2 != BUZ_LOG2_LO && BUZ_DIV_LOG2 != BUZ_LOG2_HI) begin : g_bad_buzdiv
        $error("tgp_port: buzzer divisor must be 8 or 16");
    end
    if (PIN2_MODE == P2_INVBUZ && PIN3_MODE != P3_BUZZ) begin : g_bad_pair
        $error("tgp_port: inverted buzzer needs the buzzer role on pin 3");
    end

    logic [PORT_W-1:0] reg_q;
    logic              clk_src;
    logic              clk_src_nxt;
    logic              bz_src;
    logic              bz_src_nxt;

    tgp_data_reg #(.W(PORT_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .reg_q   (reg_q)
    );

    tgp_divider #(.CNT_W(CNT_W), .A_IDX(CLK_IDX), .B_IDX(BUZ_IDX)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .a_bit (clk_src),
        .a_nxt (clk_src_nxt),
        .b_bit (bz_src),
        .b_nxt (bz_src_nxt)
    );

    // Per-pin role selection.
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        if (i == PIN_CLK && PIN2_MODE == P2_CLKOUT && CLK_DIV_LOG2 == 0) begin : g_fast
            tgp_fast_gate u_gate (
                .clk    (clk),
                .rst_n  (rst_n),
                .en_req (reg_q[i]),
                .pin    (pin_out[i])
            );
        end else if (i == PIN_CLK && PIN2_MODE == P2_CLKOUT) begin : g_clkout
            tgp_phase_gate #(.INVERT(1'b0)) u_gate (
                .clk     (clk),
                .rst_n   (rst_n),
                .src_bit (clk_src),
                .src_nxt (clk_src_nxt),
                .en_req  (reg_q[i]),
                .pin     (pin_out[i])
            );
        end else if (i == PIN_CLK && PIN2_MODE == P2_INVBUZ) begin : g_invbuz
            tgp_phase_gate #(.INVERT(1'b1)) u_gate (
                .clk     (clk),
                .rst_n   (rst_n),
                .src_bit (bz_src),
                .src_nxt (bz_src_nxt),
                .en_req  (reg_q[i]),
                .pin     (pin_out[i])
            );
        end else if (i == PIN_BUZ && PIN3_MODE == P3_BUZZ) begin : g_buzz
            tgp_phase_gate #(.INVERT(1'b0)) u_gate (
                .clk     (clk),
                .rst_n   (rst_n),
                .src_bit (bz_src),
                .src_nxt (bz_src_nxt),
                .en_req  (reg_q[i]),
                .pin     (pin_out[i])
            );
        end else begin : g_plain
            assign pin_out[i] = reg_q[i];
        end
    end

endmodule

// File: rtl/tgp_checker.sv
// Module: property checker bound to tgp_port; observes ports and the
// divider's source bits.
// Assumes: sources are the raw divider bits before gating.
module tgp_checker
    import tgp_pkg::*;
#(
    parameter int         PORT_W       = 4,
    parameter pin2_mode_e PIN2_MODE    = P2_CLKOUT,
    parameter pin3_mode_e PIN3_MODE    = P3_BUZZ,
    parameter int         CLK_DIV_LOG2 = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [PORT_W-1:0] wr_data,
    input logic              rd_en,
    input logic [PORT_W-1:0] rd_data,
    input logic [PORT_W-1:0] pin_out,
    input logic              clk_src,
    input logic              clk_src_nxt,
    input logic              bz_src,
    input logic              bz_src_nxt
);

    AST_WRITE_REACHES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pin_out[1:0] == $past(wr_data[1:0])); // R4

    AST_READ_MATCHES_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> rd_data[1:0] == pin_out[1:0]); // R3

    AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0); // R3

    AST_SRC_LOOKAHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (clk_src == $past(clk_src_nxt)) && (bz_src == $past(bz_src_nxt))); // R8

    if (PIN3_MODE == P3_BUZZ) begin : g_buz_chk
        AST_BUZ_ONLY_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            pin_out[PIN_BUZ] |-> bz_src); // R6
        AST_BUZ_RISE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pin_out[PIN_BUZ]) |-> $rose(bz_src)); // R8
        AST_BUZ_FALL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pin_out[PIN_BUZ]) |-> $fell(bz_src)); // R8
    end else begin : g_buz_plain
        AST_PIN3_PLAIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |-> rd_data[PIN_BUZ] == pin_out[PIN_BUZ]); // R1
    end

    if (PIN2_MODE == P2_CLKOUT && CLK_DIV_LOG2 > 0) begin : g_clk_chk
        AST_CLK_ONLY_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            pin_out[PIN_CLK] |-> clk_src); // R5
        AST_CLK_RISE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pin_out[PIN_CLK]) |-> $rose(clk_src)); // R8
        AST_CLK_FALL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pin_out[PIN_CLK]) |-> $fell(clk_src)); // R8
    end

    if (PIN2_MODE == P2_INVBUZ) begin : g_inv_chk
        AST_INV_ONLY_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            pin_out[PIN_CLK] |-> !bz_src); // R7
        AST_INV_RISE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pin_out[PIN_CLK]) |-> $fell(bz_src)); // R8
        AST_INV_FALL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pin_out[PIN_CLK]) |-> $rose(bz_src)); // R8
        AST_PAIR_NOT_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            !(pin_out[PIN_CLK] && pin_out[PIN_BUZ])); // R7
    end

endmodule

bind tgp_port tgp_checker #(
    .PORT_W       (PORT_W),
    .PIN2_MODE    (PIN2_MODE),
    .PIN3_MODE    (PIN3_MODE),
    .CLK_DIV_LOG2 (CLK_DIV_LOG2)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .pin_out     (pin_out),
    .clk_src     (clk_src),
    .clk_src_nxt (clk_src_nxt),
    .bz_src      (bz_src),
    .bz_src_nxt  (bz_src_nxt)
);

// File: tb/sim_tgp_port.sv
// Bench: three configurations share one write/read stimulus; a cycle
// counting model gives the expected pins from the requirements.
module sim_tgp_port;
    import tgp_pkg::*;

    localparam int PERIOD = 10;

    logic       clk     = 1'b0;
    logic       rst_n   = 1'b0;
    logic       wr_en   = 1'b0;
    logic       rd_en   = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic [3:0] p0, p1, p2;
    logic [3:0] r0, r1, r2;

    int  errs   = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    // Model state.
    int         n = 0;
    logic [3:0] rm = 4'h0;
    logic       g0c = 1'b0, g0b = 1'b0, g1b = 1'b0, g1i = 1'b0, g2f = 1'b0;
    logic       rd_cur = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    // Clock out /8 on pin 2, buzzer /16 on pin 3.
    tgp_port #(.PORT_W(4), .PIN2_MODE(P2_CLKOUT), .PIN3_MODE(P3_BUZZ),
               .CLK_DIV_LOG2(3), .BUZ_DIV_LOG2(4)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(r0), .pin_out(p0));

    // Inverted buzzer pair, buzzer /8.
    tgp_port #(.PORT_W(4), .PIN2_MODE(P2_INVBUZ), .PIN3_MODE(P3_BUZZ),
               .CLK_DIV_LOG2(1), .BUZ_DIV_LOG2(3)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(r1), .pin_out(p1));

    // Undivided clock out on pin 2, plain pin 3.
    tgp_port #(.PORT_W(4), .PIN2_MODE(P2_CLKOUT), .PIN3_MODE(P3_PLAIN),
               .CLK_DIV_LOG2(0), .BUZ_DIV_LOG2(3)) u2 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(r2), .pin_out(p2));

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s at t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    // One cycle: check at the falling edge, drive, model the rising edge,
    // then check the undivided clock pin in the high phase.
    task automatic step(input logic w, input logic [3:0] d, input logic r);
        logic [31:0] nv;
        logic [3:0]  er;
        @(negedge clk);
        g2f = rm[2];
        nv  = n;
        er  = rd_cur ? rm : 4'h0;
        chk("R1 R4 plain pins u0", {2'b00, p0[1:0]}, {2'b00, rm[1:0]});
        chk("R1 R4 plain pins u1", {2'b00, p1[1:0]}, {2'b00, rm[1:0]});
        chk("R1 plain pin3 u2",    {3'b000, p2[3]},  {3'b000, rm[3]});
        chk("R5 R8 clock-out u0",  {3'b000, p0[2]},  {3'b000, nv[2] & g0c});
        chk("R6 R8 buzzer16 u0",   {3'b000, p0[3]},  {3'b000, nv[3] & g0b});
        chk("R6 R8 buzzer8 u1",    {3'b000, p1[3]},  {3'b000, nv[2] & g1b});
        chk("R7 R8 inv buzzer u1", {3'b000, p1[2]},  {3'b000, ~nv[2] & g1i});
        chk("R5 fast pin low phase u2", {3'b000, p2[2]}, 4'h0);
        chk("R3 read u0", r0, er);
        chk("R3 read u1", r1, er);
        chk("R3 read u2", r2, er);
        wr_en   = w;
        wr_data = d;
        rd_en   = r;
        rd_cur  = r;
        @(posedge clk);
        nv = n + 1;
        if (!nv[2]) g0c = rm[2];
        if (!nv[3]) g0b = rm[3];
        if (!nv[2]) g1b = rm[3];
        if (nv[2])  g1i = rm[2];
        if (w) rm = d;
        n = n + 1;
        #(PERIOD/4);
        chk("R5 fast pin high phase u2", {3'b000, p2[2]}, {3'b000, g2f});
    endtask

    initial begin
        rd_en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R2 reset pins u0", p0, 4'h0);
        chk("R2 reset pins u1", p1, 4'h0);
        chk("R2 reset pins u2", p2, 4'h0);
        chk("R2 reset read u0", r0, 4'h0);
        chk("R2 reset read u1", r1, 4'h0);
        @(posedge clk);
        #(PERIOD/4);
        rst_n  = 1'b1;
        rd_cur = 1'b1;

        // Sweep every register value; wr_data carries junk while wr_en is low.
        for (int v = 0; v < 16; v++) begin
            step(1'b1, 4'(v), 1'b1);
            for (int k = 0; k < 33; k++) begin
                step(1'b0, ~4'(v), (k % 3) == 0);
            end
        end

        // Rapid enable toggling at every phase.
        for (int k = 0; k < 48; k++) begin
            step(1'b1, (k % 2 == 0) ? 4'hF : 4'h0, 1'b1);
        end
        // Slower toggling, period not a multiple of the dividers.
        for (int k = 0; k < 60; k++) begin
            step((k % 5) == 0, ((k / 5) % 2 == 0) ? 4'hC : 4'h3, 1'b0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule